// File: doc/BRIEF.md
# PHY Test-Port Transaction Engine

This block drives the configuration test port of a camera PHY. The port has a test clock, a test enable, an 8-bit input bus towards the PHY and an 8-bit output bus back from it. Each request writes one PHY register in two phases. The register code is presented first and the PHY takes it on the falling test clock while enable is high. The data byte follows and the PHY takes it on the next rising test clock. The byte the PHY then drives back is captured as the result of the request.

Every step of the pin sequence is held for `STEP_CYC` system clocks, so the port's setup and hold times are met. A `busy_o`/`done_o` pair reports progress. A separate active-high clear pulse of programmable width resets the PHY's test logic. It is issued on its own, with the test clock held high and enable held low for its whole length.

Top module: `phy_test_port_engine`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the first request, `tst_clk_o`=1, `tst_en_o`=0, `tst_din_o`=0, `tst_clr_o`=0, `busy_o`=0, `done_o`=0 and `result_o`=0. Reset is asynchronous and also aborts a request in progress.
- R2: A request accepted at a clock edge runs six steps, each of exactly `STEP_CYC` cycles and in this order. The pin levels are given as (clk, en, din):
  - (1, 0, code)
  - (1, 1, code)
  - (0, 1, code)
  - (0, 0, code)
  - (0, 0, data)
  - (1, 0, data)
- R3: The test clock falls only while enable is high. Enable falls only while the test clock is low. `tst_din_o` is stable across every rising test-clock edge. As a result, a PHY that follows the port protocol stores the data byte under the code.
- R4: At the end of the last step, `tst_dout_i` is captured into `result_o`, and `done_o` is high for exactly one cycle. That cycle begins `6*STEP_CYC` cycles after the accepting edge. `busy_o` is high from the accepting edge until that same edge.
- R5: `result_o` changes only at a done edge, and holds its value until the next completed request.
- R6: `start_i` is ignored while `busy_o` is high, whether a transaction or a clear pulse is in progress. The pins and the stored PHY contents are unaffected by it.
- R7: `clr_start_i` while idle raises `tst_clr_o` for `clr_len_i` cycles, or for 1 cycle when `clr_len_i` is 0. During the pulse `tst_clk_o`=1, `tst_en_o`=0 and `busy_o`=1, and `done_o` stays low.
- R8: When `start_i` and `clr_start_i` arrive in the same idle cycle, the transaction is taken and the clear is dropped. `clr_start_i` is ignored while busy.
- R9: After a request completes, the pins return to idle: clk=1, en=0, din=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a code/data transaction |
| code_i | input | 8 | Register code for the request |
| data_i | input | 8 | Data byte for the request |
| clr_start_i | input | 1 | Request a test-clear pulse |
| clr_len_i | input | CLR_W | Clear pulse width in cycles (0 means 1) |
| busy_o | output | 1 | Transaction or clear in progress |
| done_o | output | 1 | One-cycle transaction completion strobe |
| result_o | output | 8 | Byte captured from the PHY |
| tst_clk_o | output | 1 | PHY test clock |
| tst_en_o | output | 1 | PHY test enable |
| tst_din_o | output | 8 | PHY test data input |
| tst_dout_i | input | 8 | PHY test data output |
| tst_clr_o | output | 1 | PHY test clear, active high |

## Verification
The bench builds the block with `STEP_CYC`=3 and `CLR_W`=4. A step of three cycles leaves a middle cycle in which a stray start or clear request can land inside a step rather than on a step boundary. A 4-bit clear length keeps the pulse-width cases short, including the zero-length case. The bench's PHY model latches the code on the falling test clock and stores the data on the rising edge. Any misordered pin step therefore shows up as a wrong stored byte or a wrong echoed result.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CODE, PH_EN_UP, PH_CLK_DN, PH_EN_DN, PH_DATA, PH_CLK_UP, PH_CLR
  } phase_e;

  typedef struct packed {
    logic       clk;
    logic       en;
    logic       clr;
    logic [7:0] din;
  } pins_t;

  localparam pins_t PINS_IDLE = '{clk: 1'b1, en: 1'b0, clr: 1'b0, din: 8'h00};
endpackage

// File: rtl/tp_step_timer.sv
module tp_step_timer #(
  parameter int STEP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic last_o
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/tp_pin_decode.sv
module tp_pin_decode
  import tp_pkg::*;
(
  input  phase_e     phase_i,
  input  logic [7:0] code_i,
  input  logic [7:0] data_i,
  output pins_t      pins_o
);
  always_comb begin
    pins_o = PINS_IDLE;
    unique case (phase_i)
      PH_IDLE:   pins_o = PINS_IDLE;
      PH_CODE:   pins_o = '{clk: 1'b1, en: 1'b0, clr: 1'b0, din: code_i};
      PH_EN_UP:  pins_o = '{clk: 1'b1, en: 1'b1, clr: 1'b0, din: code_i};
      PH_CLK_DN: pins_o = '{clk: 1'b0, en: 1'b1, clr: 1'b0, din: code_i};
      PH_EN_DN:  pins_o = '{clk: 1'b0, en: 1'b0, clr: 1'b0, din: code_i};
      PH_DATA:   pins_o = '{clk: 1'b0, en: 1'b0, clr: 1'b0, din: data_i};
      PH_CLK_UP: pins_o = '{clk: 1'b1, en: 1'b0, clr: 1'b0, din: data_i};
      PH_CLR:    pins_o = '{clk: 1'b1, en: 1'b0, clr: 1'b1, din: 8'h00};
      default:   pins_o = PINS_IDLE;
    endcase
  end
endmodule

// File: rtl/phy_test_port_engine.sv
module phy_test_port_engine
  import tp_pkg::*;
#(
  parameter int STEP_CYC = 4,
  parameter int CLR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       code_i,
  input  logic [7:0]       data_i,
  input  logic             clr_start_i,
  input  logic [CLR_W-1:0] clr_len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       result_o,
  output logic             tst_clk_o,
  output logic             tst_en_o,
  output logic [7:0]       tst_din_o,
  input  logic [7:0]       tst_dout_i,
  output logic             tst_clr_o
);
  localparam logic [CLR_W-1:0] CLR_ONE = CLR_W'(1);

  phase_e           phase_q, phase_d;
  logic [7:0]       code_q, data_q, code_d, data_d;
  logic [CLR_W-1:0] clr_rem_q, clr_rem_d;
  logic             step_last, accept, finish;
  pins_t            pins_d, pins_q;

  assign accept = (phase_q == PH_IDLE) && start_i;
  assign finish = (phase_q == PH_CLK_UP) && step_last;
  assign code_d = accept ? code_i : code_q;
  assign data_d = accept ? data_i : data_q;

  tp_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(phase_q == PH_IDLE),
    .last_o   (step_last)
  );

  always_comb begin
    phase_d   = phase_q;
    clr_rem_d = clr_rem_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) phase_d = PH_CODE;
        else if (clr_start_i) begin
          phase_d   = PH_CLR;
          clr_rem_d = (clr_len_i == '0) ? CLR_ONE : clr_len_i;
        end
      end
      PH_CLR: begin
        if (clr_rem_q == CLR_ONE) phase_d = PH_IDLE;
        else clr_rem_d = clr_rem_q - 1'b1;
      end
      PH_CLK_UP: if (step_last) phase_d = PH_IDLE;
      default:   if (step_last) phase_d = phase_e'(phase_q + 3'd1);
    endcase
  end

  tp_pin_decode u_decode (
    .phase_i(phase_d),
    .code_i (code_d),
    .data_i (data_d),
    .pins_o (pins_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      code_q    <= '0;
      data_q    <= '0;
      clr_rem_q <= '0;
      pins_q    <= PINS_IDLE;
      done_o    <= 1'b0;
      result_o  <= '0;
    end else begin
      phase_q   <= phase_d;
      code_q    <= code_d;
      data_q    <= data_d;
      clr_rem_q <= clr_rem_d;
      pins_q    <= pins_d;
      done_o    <= finish;
      if (finish) result_o <= tst_dout_i;
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign tst_clk_o = pins_q.clk;
  assign tst_en_o  = pins_q.en;
  assign tst_din_o = pins_q.din;
  assign tst_clr_o = pins_q.clr;

  // R1, R9
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tst_clk_o && !tst_en_o && !tst_clr_o));
  // R3
  clk_fall_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tst_clk_o) |-> tst_en_o);
  // R3
  en_fall_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tst_en_o) |-> !tst_clk_o);
  // R3
  din_stable_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tst_clk_o) |-> $stable(tst_din_o));
  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  // R7
  clr_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_clr_o |-> (tst_clk_o && !tst_en_o && busy_o && !done_o));
endmodule

// File: tb/sim_phy_test_port_engine.sv
module sim_phy_test_port_engine;
  localparam int S = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clr_start = 1'b0;
  logic [7:0] code = '0, data = '0;
  logic [CW-1:0] clr_len = '0;
  logic busy, done, tclk, ten, tclr;
  logic [7:0] result, tdin, tdout;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  phy_test_port_engine #(.STEP_CYC(S), .CLR_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code), .data_i(data),
    .clr_start_i(clr_start), .clr_len_i(clr_len), .busy_o(busy), .done_o(done),
    .result_o(result), .tst_clk_o(tclk), .tst_en_o(ten), .tst_din_o(tdin),
    .tst_dout_i(tdout), .tst_clr_o(tclr)
  );

  // PHY model: code on falling clock with enable high, data on rising clock
  logic [7:0] phy_mem [256];
  logic [7:0] code_lat = '0;
  initial for (int i = 0; i < 256; i++) phy_mem[i] = 8'h00;
  always @(negedge tclk) if (ten === 1'b1) code_lat <= tdin;
  always @(posedge tclk) if (!$isunknown(tdin)) phy_mem[code_lat] <= tdin;
  assign tdout = phy_mem[code_lat];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] step_pins(input int k, input logic [7:0] c, input logic [7:0] d);
    case (k)
      0: return {1'b1, 1'b0, c};
      1: return {1'b1, 1'b1, c};
      2: return {1'b0, 1'b1, c};
      3: return {1'b0, 1'b0, c};
      4: return {1'b0, 1'b0, d};
      default: return {1'b1, 1'b0, d};
    endcase
  endfunction

  // inject: 0 none, 1 start while busy, 2 clear while busy
  task automatic run_txn(input logic [7:0] c, input logic [7:0] d, input int inject);
    logic [7:0] alt_before;
    int clr_seen = 0;
    alt_before = phy_mem[~c];
    @(negedge clk); start = 1'b1; code = c; data = d;
    @(negedge clk); start = 1'b0; code = ~c; data = 8'hEE;
    for (int k = 0; k < 6; k++) begin
      chk("R2 pins", {22'd0, tclk, ten, tdin}, {22'd0, step_pins(k, c, d)});
      chk("R4 busy", busy, 1'b1);
      chk("R4 no early done", done, 1'b0);
      if (tclr) clr_seen++;
      if (k == 1 && inject != 0) begin
        if (inject == 1) start = 1'b1; else begin clr_start = 1'b1; clr_len = 4'd2; end
        @(negedge clk); start = 1'b0; clr_start = 1'b0;
        if (tclr) clr_seen++;
        repeat (S - 1) @(negedge clk);
      end else repeat (S) @(negedge clk);
    end
    chk("R4 done", done, 1'b1);
    chk("R4 result", result, d);
    chk("R4 busy low at done", busy, 1'b0);
    chk("R3 phy stored", phy_mem[c], d);
    if (inject == 1) chk("R6 other code untouched", phy_mem[~c], alt_before);
    if (inject == 2) chk("R8 clear ignored while busy", clr_seen, 0);
    @(negedge clk);
    chk("R4 done one cycle", done, 1'b0);
    chk("R5 result held", result, d);
    chk("R9 idle pins", {tclk, ten, tdin, tclr}, {1'b1, 1'b0, 8'h00, 1'b0});
    if (inject == 1) chk("R6 no second txn", busy, 1'b0);
  endtask

  task automatic run_clr(input logic [CW-1:0] len, input int exp_w);
    int w = 0;
    @(negedge clk); clr_start = 1'b1; clr_len = len;
    @(negedge clk); clr_start = 1'b0; clr_len = 4'hF;
    while (tclr && w < 20) begin
      chk("R7 clk high en low", {tclk, ten, busy, done}, {1'b1, 1'b0, 1'b1, 1'b0});
      w++;
      @(negedge clk);
    end
    chk("R7 pulse width", w, exp_w);
    chk("R7 busy released", busy, 1'b0);
  endtask

  localparam logic [15:0] VEC [6] = '{
    16'h44_20, 16'h17_03, 16'h18_7F, 16'h19_80, 16'hFF_FF, 16'h00_A5
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {tclk, ten, tdin, tclr}, {1'b1, 1'b0, 8'h00, 1'b0});
    chk("R1 reset status", {busy, done, result}, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {tclk, ten, tdin, busy, done}, {1'b1, 1'b0, 8'h00, 1'b0, 1'b0});

    foreach (VEC[i]) run_txn(VEC[i][15:8], VEC[i][7:0], 0);

    // R6 start while busy
    run_txn(8'h21, 8'h77, 1);
    // R8 clear while busy
    run_txn(8'h35, 8'h5C, 2);

    // R7 clear pulses
    run_clr(4'd3, 3);
    run_clr(4'd0, 1);
    run_clr(4'd9, 9);

    // R6 start during clear is ignored
    @(negedge clk); clr_start = 1'b1; clr_len = 4'd4;
    @(negedge clk); clr_start = 1'b0;
    @(negedge clk); start = 1'b1; code = 8'h50; data = 8'h0D;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 start dropped during clear", {busy, tclk, ten, tclr}, {1'b0, 1'b1, 1'b0, 1'b0});
    chk("R6 result unchanged", result, 8'h5C);

    // R8 simultaneous start and clear
    @(negedge clk); start = 1'b1; clr_start = 1'b1; clr_len = 4'd5; code = 8'h61; data = 8'h3C;
    @(negedge clk); start = 1'b0; clr_start = 1'b0;
    chk("R8 transaction wins", {tclr, tclk, ten, tdin}, {1'b0, 1'b1, 1'b0, 8'h61});
    repeat (6 * S) @(negedge clk);
    chk("R8 result", result, 8'h3C);

    // R1 asynchronous reset mid-transaction
    @(negedge clk); start = 1'b1; code = 8'h70; data = 8'h11;
    @(negedge clk); start = 1'b0;
    repeat (2 * S) @(negedge clk);
    chk("R2 clock low before reset", tclk, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset pins", {tclk, ten, tdin, tclr, busy, done}, {1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0});
    chk("R1 async reset result", result, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    run_txn(8'h71, 8'h22, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule